// File: doc/BRIEF.md
# T1 Receive Sync Pulse Generator

This block produces the receive-side timing marks of a T1 framer. An upstream synchronizer reports when it has frame lock and where the line stands within the frame and the multiframe. From that point the block tracks the position itself. The bit counter has 193 positions and the frame counter counts across a 12-frame or a 24-frame multiframe. Two boundary outputs are decoded from the counters. Both change only at a rising edge of the receive clock.

The frame sync output pulses once at the start of every frame, which is an 8 kHz rate. The configurable sync output has two uses. It can mark every frame, and in that use it can stretch to two clocks on signaling frames. It can also mark only the start of each multiframe. Changes to the three configuration inputs are held back until the next frame boundary. A pulse is therefore never cut short or split by a change.

Top module: `t1_rx_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs are low after that edge and the position counters are cleared.
- R2: After any edge at which `locked` is low, both outputs are low and the counters hold at zero. The configuration that was last applied is kept.
- R3: At the first edge with `locked` high after a period without lock, the bit position is loaded from `load_bit` and the 0-based frame index is loaded from `load_frame`. The configuration inputs are applied at that same edge, and the outputs after that edge reflect the loaded position.
- R4: While locked, the bit position advances by one per clock from 0 to 192 and then returns to 0. `fsync_o` is high for exactly the one clock at bit 0 of every frame.
- R5: With `mf_mode`=0, `sync_o` is high for the clock at bit 0 of every frame.
- R6: With `mf_mode`=0 and `sig_wide`=1, `sync_o` is also high at bit 1 of signaling frames, which gives a two-clock pulse. On other frames the pulse stays one clock wide.
- R7: With `mf_mode`=1, `sync_o` is high only at bit 0 of frame index 0, and `sig_wide` has no effect.
- R8: With `ext_mf`=0, the frame index runs from 0 to 11. Signaling frames are indices 5 and 11, which are the 6th and 12th frames.
- R9: With `ext_mf`=1, the frame index runs from 0 to 23. Signaling frames are indices 5, 11, 17 and 23.
- R10: A change on `mf_mode`, `sig_wide` or `ext_mf` takes effect only at the next frame boundary. That boundary is the step from bit 192 to bit 0, or a lock load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line receive clock |
| rst | input | 1 | Synchronous active-high reset |
| locked | input | 1 | Frame lock indication from the synchronizer |
| load_bit | input | 8 | Bit position (0 to 192) to load when lock is gained |
| load_frame | input | 5 | 0-based frame index to load when lock is gained |
| mf_mode | input | 1 | 0: sync marks frames, 1: sync marks multiframes |
| sig_wide | input | 1 | Widen frame-mode sync pulse on signaling frames |
| ext_mf | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| sync_o | output | 1 | Configurable frame or multiframe boundary pulse |
| fsync_o | output | 1 | Frame boundary pulse, every frame |

## Verification
Several functions meet at bit 0 of frame index 0. The multiframe mark, the frame pulse and the frame-counter wrap all fall there. When a configuration change is pending, its application falls at the same edge, and the stretched second clock of a signaling-frame pulse lies right beside that edge. The bench provokes these coincidences in three ways. It changes configuration in mid-frame and lets that frame run into the multiframe wrap. It switches the multiframe length while the frame index lies beyond the shorter range. It gains lock with the loaded position on bit 192, on bit 1 of a signaling frame, and on the last frame. A scoreboard model fed from the requirements predicts both outputs for every clock, and each output is compared with the model.

// File: rtl/t1_sync_pkg.sv
package t1_sync_pkg;

    // Configuration applied at frame boundaries.
    typedef struct packed {
        logic mf_mode;   // 1: configurable sync marks multiframe start
        logic sig_wide;  // widen frame-mode pulse on signaling frames
        logic ext_mf;    // 1: 24-frame multiframe, 0: 12-frame
    } sync_cfg_t;

    // Counter state handed from the position tracker to the shaper.
    typedef struct packed {
        logic       run;
        logic [7:0] bit_pos;
        logic [4:0] frm_idx;
    } pos_t;

    // A 0-based frame index is a signaling frame when its 1-based number
    // is a multiple of the stride.
    function automatic logic sig_hit(input int unsigned idx, input int unsigned stride);
        return ((idx + 1) % stride) == 0;
    endfunction

endpackage

// File: rtl/t1_pos_cnt.sv
module t1_pos_cnt #(
    parameter int BITS_PER_FRAME = 193,
    parameter int SF_FRAMES      = 12,
    parameter int EXT_FRAMES     = 24,
    parameter int BIT_W          = 8,
    parameter int FRM_W          = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic [BIT_W-1:0] ld_bit,
    input  logic [FRM_W-1:0] ld_frm,
    input  logic             ext_in,
    output logic             run_q,
    output logic [BIT_W-1:0] bit_q,
    output logic [FRM_W-1:0] frm_q,
    output logic             bound_o
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_FRAME - 1);
    localparam logic [FRM_W-1:0] SF_LAST  = FRM_W'(SF_FRAMES - 1);
    localparam logic [FRM_W-1:0] EXT_LAST = FRM_W'(EXT_FRAMES - 1);

    logic             at_last;
    logic [FRM_W-1:0] frm_last;

    assign at_last  = (bit_q == LAST_BIT);
    assign frm_last = ext_in ? EXT_LAST : SF_LAST;
    assign bound_o  = !rst && locked && (!run_q || at_last);

    always_ff @(posedge clk) begin
        if (rst || !locked) begin
            run_q <= 1'b0;
            bit_q <= '0;
            frm_q <= '0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            bit_q <= ld_bit;
            frm_q <= ld_frm;
        end else if (at_last) begin
            bit_q <= '0;
            frm_q <= (frm_q >= frm_last) ? '0 : frm_q + FRM_W'(1);
        end else begin
            bit_q <= bit_q + BIT_W'(1);
        end
    end

    // R2: losing lock clears the tracker on the following edge
    p_unlock_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !locked |=> (!run_q && bit_q == '0 && frm_q == '0));

    // R4: a running, locked tracker steps the bit position by one
    p_bit_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q && locked && !at_last) |=> (bit_q == $past(bit_q) + BIT_W'(1)));

    // R4: the bit position wraps to zero after the last bit
    p_bit_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q && locked && at_last) |=> (bit_q == '0));
endmodule

// File: rtl/t1_cfg_hold.sv
module t1_cfg_hold
    import t1_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bound,
    input  sync_cfg_t cfg_in,
    output sync_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bound) begin
            cfg_q <= cfg_in;
        end
    end

    // R10: the applied configuration moves only at a frame boundary
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bound |=> $stable(cfg_q));
endmodule

// File: rtl/t1_pulse_shape.sv
module t1_pulse_shape
    import t1_sync_pkg::*;
#(
    parameter int SF_FRAMES = 12,
    parameter int SIG_EVERY = 6
) (
    input  pos_t      pos,
    input  sync_cfg_t cfg,
    output logic      sync_o,
    output logic      fsync_o
);
    logic at_bit0;
    logic at_bit1;
    logic sig_frame;
    logic mf_start;

    assign at_bit0   = pos.run && (pos.bit_pos == 8'd0);
    assign at_bit1   = pos.run && (pos.bit_pos == 8'd1);
    assign sig_frame = sig_hit(32'(pos.frm_idx), SIG_EVERY)
                       && (cfg.ext_mf || (32'(pos.frm_idx) < SF_FRAMES));
    assign mf_start  = at_bit0 && (pos.frm_idx == 5'd0);

    assign fsync_o = at_bit0;
    assign sync_o  = cfg.mf_mode ? mf_start
                                 : (at_bit0 || (cfg.sig_wide && sig_frame && at_bit1));
endmodule

// File: rtl/t1_rx_sync_gen.sv
module t1_rx_sync_gen
    import t1_sync_pkg::*;
#(
    parameter int BITS_PER_FRAME = 193,
    parameter int SF_FRAMES      = 12,
    parameter int EXT_FRAMES     = 24,
    parameter int SIG_EVERY      = 6,
    localparam int BIT_W         = $clog2(BITS_PER_FRAME),
    localparam int FRM_W         = $clog2(EXT_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic [BIT_W-1:0] load_bit,
    input  logic [FRM_W-1:0] load_frame,
    input  logic             mf_mode,
    input  logic             sig_wide,
    input  logic             ext_mf,
    output logic             sync_o,
    output logic             fsync_o
);
    sync_cfg_t        cfg_in;
    sync_cfg_t        cfg_q;
    logic             run_q;
    logic [BIT_W-1:0] bit_q;
    logic [FRM_W-1:0] frm_q;
    logic             bound;
    pos_t             pos;

    assign cfg_in = '{mf_mode: mf_mode, sig_wide: sig_wide, ext_mf: ext_mf};
    assign pos    = '{run: run_q, bit_pos: 8'(bit_q), frm_idx: 5'(frm_q)};

    t1_pos_cnt #(
        .BITS_PER_FRAME(BITS_PER_FRAME),
        .SF_FRAMES     (SF_FRAMES),
        .EXT_FRAMES    (EXT_FRAMES),
        .BIT_W         (BIT_W),
        .FRM_W         (FRM_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .locked (locked),
        .ld_bit (load_bit),
        .ld_frm (load_frame),
        .ext_in (ext_mf),
        .run_q  (run_q),
        .bit_q  (bit_q),
        .frm_q  (frm_q),
        .bound_o(bound)
    );

    t1_cfg_hold u_cfg (
        .clk   (clk),
        .rst   (rst),
        .bound (bound),
        .cfg_in(cfg_in),
        .cfg_q (cfg_q)
    );

    t1_pulse_shape #(
        .SF_FRAMES(SF_FRAMES),
        .SIG_EVERY(SIG_EVERY)
    ) u_shape (
        .pos    (pos),
        .cfg    (cfg_q),
        .sync_o (sync_o),
        .fsync_o(fsync_o)
    );

    // R4: the frame pulse never lasts beyond one clock
    p_fsync_single_r4: assert property (@(posedge clk) disable iff (rst)
        fsync_o |=> !fsync_o);

    // R2: an edge without lock leaves both outputs low
    p_unlock_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!locked) |-> (!sync_o && !fsync_o));

    // R6: a sync clock outside bit 0 is only the tail of a widened pulse
    p_wide_tail_r6: assert property (@(posedge clk) disable iff (rst)
        (sync_o && !fsync_o && $past(run_q)) |-> $past(sync_o));

    // R7: in multiframe mode the sync pulse is always a single clock
    p_mf_single_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_o && cfg_q.mf_mode) |=> !sync_o);
endmodule

// File: tb/t1_rx_sync_gen_bench.sv
module t1_rx_sync_gen_bench;
    localparam int BPF = 193;
    localparam int SFN = 12;
    localparam int EFN = 24;

    logic       clk = 1'b0;
    logic       rst, locked, mf_mode, sig_wide, ext_mf;
    logic [7:0] load_bit;
    logic [4:0] load_frame;
    logic       sync_o, fsync_o;

    always #4 clk = ~clk;   // 125 MHz

    t1_rx_sync_gen u_t1_rx_sync_gen (
        .clk(clk), .rst(rst), .locked(locked),
        .load_bit(load_bit), .load_frame(load_frame),
        .mf_mode(mf_mode), .sig_wide(sig_wide), .ext_mf(ext_mf),
        .sync_o(sync_o), .fsync_o(fsync_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";
    logic [1:0] exp_q[$];
    string      tag_q[$];

    // reference state, built from the requirements
    int m_run = 0, m_bit = 0, m_frm = 0;
    int m_mf = 0, m_wide = 0, m_ext = 0;

    task automatic tick();
        logic es, ef, sig;
        @(posedge clk);
        if (rst) begin
            m_run = 0; m_bit = 0; m_frm = 0; m_mf = 0; m_wide = 0; m_ext = 0;
        end else if (!locked) begin
            m_run = 0; m_bit = 0; m_frm = 0;
        end else if (m_run == 0) begin
            m_run = 1; m_bit = int'(load_bit); m_frm = int'(load_frame);
            m_mf = int'(mf_mode); m_wide = int'(sig_wide); m_ext = int'(ext_mf);
        end else if (m_bit == BPF - 1) begin
            m_mf = int'(mf_mode); m_wide = int'(sig_wide); m_ext = int'(ext_mf);
            m_bit = 0;
            m_frm = (m_frm >= (m_ext != 0 ? EFN : SFN) - 1) ? 0 : m_frm + 1;
        end else begin
            m_bit = m_bit + 1;
        end
        sig = (m_frm == 5 || m_frm == 11) || (m_ext != 0 && (m_frm == 17 || m_frm == 23));
        ef  = (m_run != 0) && m_bit == 0;
        if (m_run == 0) es = 1'b0;
        else if (m_mf != 0) es = (m_bit == 0 && m_frm == 0);
        else es = (m_bit == 0) || (m_wide != 0 && sig && m_bit == 1);
        exp_q.push_back({es, ef});
        tag_q.push_back(cur_tag);
        #2;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({sync_o, fsync_o} !== e) begin
                errors++;
                $display("FAIL %s: sync/fsync actual %b%b expected %b%b at %0t",
                         t, sync_o, fsync_o, e[1], e[0], $time);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; locked = 0; mf_mode = 0; sig_wide = 0; ext_mf = 0;
        load_bit = 0; load_frame = 0;
        #2;
        cur_tag = "R1 reset"; run_n(3);
        rst = 0;
        cur_tag = "R2 idle without lock"; run_n(10);

        // lock near end of the last superframe frame
        load_bit = 8'd190; load_frame = 5'd11; locked = 1;
        cur_tag = "R3 load"; tick();
        cur_tag = "R4 R5 frame mode"; run_n(400);

        // widen requested mid-frame: must wait for the boundary
        sig_wide = 1;
        cur_tag = "R10 wide pending"; run_n(150);
        cur_tag = "R6 R8 wide signaling"; run_n(BPF * 13);

        mf_mode = 1;
        cur_tag = "R7 R10 multiframe mode"; run_n(BPF * 13);

        ext_mf = 1;
        cur_tag = "R9 R7 extended multiframe"; run_n(BPF * 26);

        mf_mode = 0;
        cur_tag = "R9 R6 extended wide"; run_n(BPF * 25);

        locked = 0;
        cur_tag = "R2 lock lost"; run_n(20);
        mf_mode = 1;   // applied only at the next lock load
        cur_tag = "R2 R10 cfg while unlocked"; run_n(5);

        load_bit = 8'd192; load_frame = 5'd23; locked = 1;
        cur_tag = "R3 load last bit"; tick();
        cur_tag = "R9 R4 after load"; run_n(BPF * 3);

        // drop to superframe while index may exceed 11
        ext_mf = 0; mf_mode = 0;
        cur_tag = "R8 R10 length switch"; run_n(BPF * 14);

        locked = 0; run_n(3);
        load_bit = 8'd1; load_frame = 5'd5; locked = 1;
        cur_tag = "R3 R6 load on bit 1"; tick();
        cur_tag = "R6 R8 after load"; run_n(BPF * 2);

        rst = 1;
        cur_tag = "R1 reset while running"; run_n(3);
        rst = 0; locked = 0;
        cur_tag = "R2 final idle"; run_n(3);

        @(negedge clk);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule